// File: doc/BRIEF.md
# Interrupt Status and IRQ Output

This block collects single-cycle event indications from the surrounding peripherals into a 32-bit sticky status word and turns the enabled part of that word into one interrupt request pin. Some causes arrive as plain pulses. Others are derived inside the block from threshold crossings: a general-purpose down-timer wrapping from zero to all-ones, the top bit of a dropped-frame counter rising (the counter passing its midpoint), and a received packet length above 2048 bytes. A software-requested cause and a power-management cause complete the set.

The host reaches the block through a simple synchronous register port. The port has three words: status, enable mask and configuration. Status bits are cleared by writing 1 to them. The configuration word selects push-pull or open-drain drive for the pin and its polarity in push-pull mode. It holds the software-interrupt request bit and a minimum deassertion interval. That interval keeps the pin released for a programmable number of extra cycles after each deassertion, for every cause except power management.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status word, the enable mask and the configuration word read 0, and the pin is released (irq_oe = 0, irq_o = 0).
- R2: Writing the status word (address 0) clears every bit written as 1 and leaves every bit written as 0 unchanged; a cleared bit reads 0 in the next cycle.
- R3: When an event and a write-1-clear reach the same status bit in the same cycle, the bit ends up set.
- R4: Only status bits 0 to 10 and 31 exist. Bit 0 is power management, bit 1 is timer wrap, bit 2 is dropped-frame midpoint, bit 3 is long packet, bits 4 to 10 follow src_evt[0] to src_evt[6], and bit 31 is software. All other bits of the status word and the mask (address 1) read 0 whatever is written.
- R5: Status bit 31 sets once when the software request bit (configuration bit 2, address 2) changes from 0 to 1; once cleared, it stays clear while the request bit remains 1.
- R6: Status bit 1 sets when gpt_count moves from 0x0000 in one cycle to 0xFFFF in the next, and not on any other change.
- R7: Status bit 2 sets when drop_cnt_msb changes from 0 to 1, and not while it stays 1.
- R8: Status bit 3 sets when rx_len_vld is high with rx_len greater than 2048; a length of exactly 2048 does not set it.
- R9: Status bit 0 sets on a pme_evt pulse and clears on a write of 1 like any other bit.
- R10: The internal request is active one cycle after (status AND mask) becomes nonzero and inactive one cycle after it becomes zero (when no holdoff runs); masked bits stay visible in the status word without raising it.
- R11: In push-pull mode (configuration bit 0 = 1) irq_oe is 1 and irq_o equals the request when configuration bit 1 is 1, its inverse when bit 1 is 0.
- R12: In open-drain mode (configuration bit 0 = 0) irq_o is always 0, irq_oe is 1 exactly while the request is active, and the polarity bit has no effect.
- R13: With a holdoff value N in configuration bits 15:8, after the request drops, non-power-management causes cannot raise it again for N+1 cycles; N = 0 adds no extra delay.
- R14: A pending, enabled power-management bit raises the request one cycle after it is set, even while the holdoff is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 mask, 2 configuration |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| pme_evt | input | 1 | Power-management event pulse |
| src_evt | input | 7 | Plain event pulses for status bits 4 to 10 |
| gpt_count | input | 16 | Current value of the general-purpose down-timer |
| drop_cnt_msb | input | 1 | Top bit of the dropped-frame counter |
| rx_len | input | 14 | Length in bytes of the packet just received |
| rx_len_vld | input | 1 | rx_len is valid this cycle |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
An event presented in one cycle is readable in the status word after the next clock edge. The pin follows one edge later, because the request is registered. A write-1-clear likewise shows in the status word one edge after the write and drops the pin one edge after that. A configuration write changes the pin drive at the same edge as the write. The bench drives inputs just after a rising edge and queues each expected value for the cycle in which it falls due. The monitor compares the queued items at the falling edge of that cycle. The holdoff checks walk the pin one cycle at a time across the whole N+1-cycle window. They confirm that it stays released up to the last cycle and asserts exactly at the end.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  localparam int STAT_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int HOLD_W   = 8;
  localparam int NUM_SRC  = 7;
  localparam int TMR_W    = 16;
  localparam int LEN_W    = 14;
  localparam int LEN_MAX  = 2048;

  localparam int BIT_PME  = 0;
  localparam int BIT_TMR  = 1;
  localparam int BIT_DROP = 2;
  localparam int BIT_LONG = 3;
  localparam int BIT_SRC0 = 4;
  localparam int BIT_SW   = 31;

  localparam logic [STAT_W-1:0] STAT_IMPL = 32'h8000_07FF;

  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_CFG  = 2'd2;

  localparam int CFG_PP      = 0;
  localparam int CFG_POL     = 1;
  localparam int CFG_SW      = 2;
  localparam int CFG_HOLD_LO = 8;

  typedef struct packed {
    logic [HOLD_W-1:0] hold;
    logic              sw_req;
    logic              pol_hi;
    logic              push_pull;
  } irq_cfg_t;

endpackage

// File: rtl/irq_evt_detect.sv
module irq_evt_detect
  import irq_stat_pkg::*;
#(
  parameter int W       = STAT_W,
  parameter int N_SRC   = NUM_SRC,
  parameter int T_W     = TMR_W,
  parameter int L_W     = LEN_W,
  parameter int L_MAX   = LEN_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pme_evt,
  input  logic [N_SRC-1:0] src_evt,
  input  logic [T_W-1:0]   gpt_count,
  input  logic             drop_cnt_msb,
  input  logic [L_W-1:0]   rx_len,
  input  logic             rx_len_vld,
  input  logic             sw_req,
  output logic [W-1:0]     set_vec
);

  localparam logic [L_W-1:0] LEN_LIMIT = L_W'(L_MAX);

  logic [T_W-1:0] gpt_prev_q;
  logic           drop_prev_q;
  logic           sw_prev_q;
  logic           hist_vld_q;
  logic           tmr_wrap;
  logic           drop_half;
  logic           long_pkt;
  logic           sw_rise;
  logic [N_SRC-1:0] src_set;

  always_comb begin
    tmr_wrap  = hist_vld_q && (gpt_prev_q == '0) && (gpt_count == '1);
    drop_half = hist_vld_q && !drop_prev_q && drop_cnt_msb;
    long_pkt  = rx_len_vld && (rx_len > LEN_LIMIT);
    sw_rise   = sw_req && !sw_prev_q;
  end

  // history registers, updated every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpt_prev_q  <= '0;
      drop_prev_q <= 1'b0;
      sw_prev_q   <= 1'b0;
      hist_vld_q  <= 1'b0;
    end else begin
      gpt_prev_q  <= gpt_count;
      drop_prev_q <= drop_cnt_msb;
      sw_prev_q   <= sw_req;
      hist_vld_q  <= 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      assign src_set[g] = src_evt[g];
    end
  endgenerate

  always_comb begin
    set_vec = '0;
    set_vec[BIT_PME]  = pme_evt;
    set_vec[BIT_TMR]  = tmr_wrap;
    set_vec[BIT_DROP] = drop_half;
    set_vec[BIT_LONG] = long_pkt;
    set_vec[BIT_SRC0 +: N_SRC] = src_set;
    set_vec[BIT_SW]   = sw_rise;
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_stat_pkg::*;
#(
  parameter int            W    = STAT_W,
  parameter logic [W-1:0]  IMPL = STAT_IMPL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] status_q
);

  logic [W-1:0] stat_nxt;
  logic [W-1:0] clr_eff;
  logic         stat_en;

  always_comb begin
    clr_eff  = clr_en ? clr_bits : '0;
    stat_en  = clr_en || (|set_vec);
    stat_nxt = (set_vec | (status_q & ~clr_eff)) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= '0;
    else if (stat_en) status_q <= stat_nxt;
  end

  // R2
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((status_q & $past(clr_bits) & ~$past(set_vec)) == '0));

  // R3
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & IMPL)) |=> ((status_q & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_stat_pkg::*;
#(
  parameter int W     = STAT_W,
  parameter int H_W   = HOLD_W,
  parameter int P_BIT = BIT_PME
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend_vec,
  input  irq_cfg_t     cfg,
  output logic         irq_o,
  output logic         irq_oe
);

  localparam logic [W-1:0] PME_ONLY = W'(1) << P_BIT;

  logic           pme_pend;
  logic           oth_pend;
  logic           act_q;
  logic           act_nxt;
  logic [H_W-1:0] hold_q;
  logic [H_W-1:0] hold_nxt;
  logic           hold_idle;

  always_comb begin
    pme_pend  = pend_vec[P_BIT];
    oth_pend  = |(pend_vec & ~PME_ONLY);
    hold_idle = (hold_q == '0);
    act_nxt   = pme_pend || (oth_pend && hold_idle);
    if (act_q && !act_nxt)  hold_nxt = cfg.hold;
    else if (!hold_idle)    hold_nxt = hold_q - 1'b1;
    else                    hold_nxt = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      act_q  <= act_nxt;
      hold_q <= hold_nxt;
    end
  end

  always_comb begin
    if (cfg.push_pull) begin
      irq_oe = 1'b1;
      irq_o  = cfg.pol_hi ? act_q : !act_q;
    end else begin
      irq_oe = act_q;
      irq_o  = 1'b0;
    end
  end

  // R10
  no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec == '0) |=> !act_q);

  // R14
  pme_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pme_pend |=> act_q);

  // R13
  holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_idle && !pme_pend) |=> !act_q);

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_stat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [STAT_W-1:0]   reg_wdata,
  output logic [STAT_W-1:0]   reg_rdata,
  input  logic                pme_evt,
  input  logic [NUM_SRC-1:0]  src_evt,
  input  logic [TMR_W-1:0]    gpt_count,
  input  logic                drop_cnt_msb,
  input  logic [LEN_W-1:0]    rx_len,
  input  logic                rx_len_vld,
  output logic                irq_o,
  output logic                irq_oe
);

  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] mask_nxt;
  logic              mask_en;
  irq_cfg_t          cfg_q;
  irq_cfg_t          cfg_nxt;
  logic              cfg_en;
  logic              stat_wr;

  // write decode
  always_comb begin
    stat_wr  = reg_wr && (reg_addr == A_STAT);
    mask_en  = reg_wr && (reg_addr == A_MASK);
    cfg_en   = reg_wr && (reg_addr == A_CFG);
    mask_nxt = reg_wdata & STAT_IMPL;
    cfg_nxt  = '{hold:      reg_wdata[CFG_HOLD_LO +: HOLD_W],
                 sw_req:    reg_wdata[CFG_SW],
                 pol_hi:    reg_wdata[CFG_POL],
                 push_pull: reg_wdata[CFG_PP]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (mask_en) mask_q <= mask_nxt;
      if (cfg_en)  cfg_q  <= cfg_nxt;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT: reg_rdata = status_q;
      A_MASK: reg_rdata = mask_q;
      A_CFG: begin
        reg_rdata[CFG_PP]                 = cfg_q.push_pull;
        reg_rdata[CFG_POL]                = cfg_q.pol_hi;
        reg_rdata[CFG_SW]                 = cfg_q.sw_req;
        reg_rdata[CFG_HOLD_LO +: HOLD_W]  = cfg_q.hold;
      end
      default: reg_rdata = '0;
    endcase
  end

  irq_evt_detect #(
    .W(STAT_W), .N_SRC(NUM_SRC), .T_W(TMR_W), .L_W(LEN_W), .L_MAX(LEN_MAX)
  ) u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .pme_evt      (pme_evt),
    .src_evt      (src_evt),
    .gpt_count    (gpt_count),
    .drop_cnt_msb (drop_cnt_msb),
    .rx_len       (rx_len),
    .rx_len_vld   (rx_len_vld),
    .sw_req       (cfg_q.sw_req),
    .set_vec      (set_vec)
  );

  irq_status_bank #(
    .W(STAT_W), .IMPL(STAT_IMPL)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_en   (stat_wr),
    .clr_bits (reg_wdata),
    .status_q (status_q)
  );

  irq_pin_ctrl #(
    .W(STAT_W), .H_W(HOLD_W), .P_BIT(BIT_PME)
  ) u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_vec (status_q & mask_q),
    .cfg      (cfg_q),
    .irq_o    (irq_o),
    .irq_oe   (irq_oe)
  );

  // R4
  mask_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_en |=> ((mask_q & ~STAT_IMPL) == '0));

endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  import irq_stat_pkg::*;

  logic              clk;
  logic              rst_n;
  logic              reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic              pme_evt;
  logic [NUM_SRC-1:0] src_evt;
  logic [TMR_W-1:0]  gpt_count;
  logic              drop_cnt_msb;
  logic [LEN_W-1:0]  rx_len;
  logic              rx_len_vld;
  logic              irq_o;
  logic              irq_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    string       req;
    bit          is_pin;
    logic [31:0] exp;
  } sb_item_t;

  sb_item_t sb_q[$];

  irq_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pme_evt(pme_evt),
    .src_evt(src_evt), .gpt_count(gpt_count), .drop_cnt_msb(drop_cnt_msb),
    .rx_len(rx_len), .rx_len_vld(rx_len_vld), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_pin ? {30'b0, irq_oe, irq_o} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic exp_rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string r);
    sb_item_t it;
    reg_addr = a;
    it.req = r; it.is_pin = 1'b0; it.exp = e;
    sb_q.push_back(it);
    tick();
  endtask

  // e = {irq_oe, irq_o}
  task automatic exp_pin(input logic [1:0] e, input string r);
    sb_item_t it;
    it.req = r; it.is_pin = 1'b1; it.exp = {30'b0, e};
    sb_q.push_back(it);
    tick();
  endtask

  task automatic pulse_src(input int idx);
    src_evt[idx] = 1'b1;
    tick();
    src_evt = '0;
  endtask

  task automatic pulse_pme();
    pme_evt = 1'b1;
    tick();
    pme_evt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    pme_evt = 1'b0; src_evt = '0; gpt_count = '0; drop_cnt_msb = 1'b0;
    rx_len = '0; rx_len_vld = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    exp_rd(A_STAT, 32'h0, "R1 status");
    exp_rd(A_MASK, 32'h0, "R1 mask");
    exp_rd(A_CFG,  32'h0, "R1 config");
    exp_pin(2'b00, "R1 pin released");

    // R4 reserved mask bits
    wr(A_MASK, 32'hFFFF_FFFF);
    exp_rd(A_MASK, 32'h8000_07FF, "R4 mask reserved");

    // push-pull, active high, no holdoff
    wr(A_CFG, 32'h3);
    exp_pin(2'b10, "R11 inactive high-pol");

    // R10 source pulse raises request
    pulse_src(0);
    exp_rd(A_STAT, 32'h10, "R10 status bit4");
    exp_pin(2'b11, "R10 irq asserted");

    // R2 write 0 keeps, write 1 clears
    wr(A_STAT, 32'hFFFF_FFEF);
    exp_rd(A_STAT, 32'h10, "R2 zero keeps");
    wr(A_STAT, 32'h10);
    exp_rd(A_STAT, 32'h0, "R2 one clears");
    exp_pin(2'b10, "R10 irq released");

    // R3 event and clear in the same cycle
    src_evt[1] = 1'b1; reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h20;
    tick();
    src_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
    exp_rd(A_STAT, 32'h20, "R3 event wins");
    wr(A_STAT, 32'h20);
    tick(); tick();

    // R11 active-low push-pull
    wr(A_CFG, 32'h1);
    exp_pin(2'b11, "R11 low-pol inactive");
    pulse_src(2);
    tick();
    exp_pin(2'b10, "R11 low-pol active");

    // R12 open-drain ignores polarity
    wr(A_CFG, 32'h2);
    exp_pin(2'b10, "R12 open-drain active");
    wr(A_STAT, 32'h40);
    tick();
    exp_pin(2'b00, "R12 open-drain released");
    wr(A_CFG, 32'h3);

    // R9 power-management bit
    pulse_pme();
    exp_rd(A_STAT, 32'h1, "R9 pme set");
    wr(A_STAT, 32'h1);
    exp_rd(A_STAT, 32'h0, "R9 pme cleared");
    tick();

    // R5 software interrupt on request rise
    wr(A_CFG, 32'h7);
    tick();
    exp_rd(A_STAT, 32'h8000_0000, "R5 sw set");
    wr(A_STAT, 32'h8000_0000);
    tick();
    exp_rd(A_STAT, 32'h0, "R5 sw stays clear");
    wr(A_CFG, 32'h3);
    tick(); tick();

    // R6 timer wrap
    gpt_count = 16'h0005; tick();
    gpt_count = 16'h0000; tick();
    gpt_count = 16'hFFFF; tick();
    exp_rd(A_STAT, 32'h2, "R6 wrap sets");
    wr(A_STAT, 32'h2);
    gpt_count = 16'h0001; tick();
    gpt_count = 16'h0000; tick();
    exp_rd(A_STAT, 32'h0, "R6 no wrap");
    tick(); tick();

    // R7 dropped-frame midpoint
    drop_cnt_msb = 1'b0; tick();
    drop_cnt_msb = 1'b1; tick();
    exp_rd(A_STAT, 32'h4, "R7 msb rise");
    wr(A_STAT, 32'h4);
    tick();
    exp_rd(A_STAT, 32'h0, "R7 msb held");
    drop_cnt_msb = 1'b0;
    tick(); tick();

    // R8 long packet
    rx_len = 14'd2048; rx_len_vld = 1'b1; tick(); rx_len_vld = 1'b0;
    exp_rd(A_STAT, 32'h0, "R8 2048 ignored");
    rx_len = 14'd2049; rx_len_vld = 1'b1; tick(); rx_len_vld = 1'b0;
    exp_rd(A_STAT, 32'h8, "R8 2049 sets");
    wr(A_STAT, 32'h8);
    tick(); tick();

    // R10 mask gates the request
    wr(A_MASK, 32'hFFFF_FFDF);
    pulse_src(1);
    tick();
    exp_pin(2'b10, "R10 masked no irq");
    exp_rd(A_STAT, 32'h20, "R10 masked visible");
    wr(A_MASK, 32'hFFFF_FFFF);
    tick();
    exp_pin(2'b11, "R10 unmask irq");
    wr(A_STAT, 32'h20);
    tick(); tick();

    // R13 holdoff of 5
    wr(A_CFG, 32'h0503);
    pulse_src(0);
    tick();
    wr(A_STAT, 32'h10);
    tick();
    pulse_src(0);
    for (int k = 0; k < 5; k++) exp_pin(2'b10, "R13 held off");
    exp_pin(2'b11, "R13 reassert after window");
    wr(A_STAT, 32'h10);
    repeat (8) tick();

    // R14 PME bypasses holdoff
    pulse_src(0);
    tick();
    wr(A_STAT, 32'h10);
    tick();
    pulse_pme();
    exp_pin(2'b10, "R14 pme pending");
    exp_pin(2'b11, "R14 pme during holdoff");

    tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule